// File: doc/BRIEF.md
# Echo Canceller Channel Path Controller

This block sits around an echo canceller on a time-division multiplexed voice link carrying `NCH` channels per frame (32 by default). Each slot presents one receive-side sample, one send-side sample and the canceller's echo estimate for the current channel. The block delays both directions by whole frames and removes the echo estimate on the send direction. It replaces a direction's output with a quiet code when that direction is muted. For every slot it also tells the adaptive filter whether to clear, freeze or update its coefficients for that channel.

Each channel has four control bits, loaded through a per-channel write port. A write is staged and becomes active only at the next frame boundary, so a channel never changes state in the middle of a frame. In bypass, both directions pass unchanged and the filter is told to clear. Once bypass has been active for one complete frame, a per-channel clear-done flag is raised. The flag stays up until bypass is released.

Top module: `echo_path_ctrl`

## Requirements
- R1: When not receive-muted, `rOut` after the slot-`k` update equals the `rinData` sampled at slot `k - 2*NCH`, in every state. Slots count only cycles with `slotValid` high, and all history before reset reads as zero.
- R2: When neither bypassed nor send-muted, `sOut` equals the `sinData` from slot `k - 3*NCH` minus the current slot's `echoEst`. Both are read as signed two's-complement values, and the result is clamped to the range -128..127 (for `W` = 8).
- R3: In bypass, and when not send-muted, `sOut` equals the `sinData` from slot `k - 2*NCH` unchanged, and `echoEst` has no effect.
- R4: When the receive mute bit is set, `rOut` carries `QUIET` (default 8'hFF), whether or not bypass is set.
- R5: When the send mute bit is set, `sOut` carries `QUIET`, whether or not bypass is set. Mute overrides bypass.
- R6: Each output slot asserts exactly one coefficient strobe. `coefClear` is asserted in bypass. Otherwise `coefFreeze` is asserted when adaptation is disabled, and `coefUpdate` is asserted when it is enabled.
- R7: `clearDone` is 1 in a channel's slot only if bypass was active for that channel during the whole previous frame and is still active. It returns to 0 in the first frame after bypass is released.
- R8: `ctlBits` encodes bit0 = send mute, bit1 = receive mute, bit2 = bypass and bit3 = adaptation disable. A write to channel `ctlChan` becomes active starting at the next channel-0 slot, including a write made in the slot of channel `NCH-1`. Until then the channel keeps its old behaviour.
- R9: During and right after reset, `outValid` is 0, `rOut` and `sOut` are 0, and every channel is unmuted, not bypassed and adapting.
- R10: `outValid` is high in the cycle after each `slotValid` cycle and only then. `chanO` gives the slot's channel, which starts at 0 after reset and steps by one, modulo `NCH`, per slot. The outputs hold their values across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 1 | One channel slot is presented this cycle |
| rinData | input | W | Receive-side input sample |
| sinData | input | W | Send-side input sample |
| echoEst | input | W | Echo estimate for the current slot's channel |
| ctlWe | input | 1 | Control write strobe |
| ctlChan | input | $clog2(NCH) | Channel addressed by the write |
| ctlBits | input | 4 | Control bits: send mute, receive mute, bypass, adaptation disable |
| outValid | output | 1 | Outputs updated for one slot |
| rOut | output | W | Receive-side output sample |
| sOut | output | W | Send-side output sample |
| chanO | output | $clog2(NCH) | Channel of the output slot |
| coefClear | output | 1 | Clear coefficients for this channel |
| coefFreeze | output | 1 | Hold coefficients for this channel |
| coefUpdate | output | 1 | Adapt coefficients for this channel |
| clearDone | output | 1 | Bypass has been held for at least one full frame |

## Verification
A control write and a frame boundary can land in the same cycle. The bench provokes this by writing channel 0 in the slot of the last channel, and it expects the new bits to govern the very next slot. Mute and bypass can also apply to one channel in the same slot. The bench sets both on some channels and expects the quiet code to win on the muted direction, while the other direction still follows the bypass latency and the clear strobe. A scoreboard model, driven by the requirement rules, predicts every slot, and mid-frame writes check that channels later in the same frame keep their old behaviour.

// File: rtl/ecpath_pkg.sv
package ecpath_pkg;
  // Per-channel control word; bit order matches the write port encoding.
  typedef struct packed {
    logic adaptDis;  // bit3
    logic bypass;    // bit2
    logic muteR;     // bit1
    logic muteS;     // bit0
  } chanCtl_t;

  // Strobes the control side hands to the datapath for the current slot.
  typedef struct packed {
    logic muteS;
    logic muteR;
    logic bypass;
    logic coefClear;
    logic coefFreeze;
    logic coefUpdate;
    logic clearDone;
  } slotStrobe_t;
endpackage

// File: rtl/ecpath_delay.sv
module ecpath_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] line [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (en) begin
      line[0] <= dIn;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  // Value shifted in DEPTH enabled cycles ago.
  assign dOut = line[DEPTH-1];
endmodule

// File: rtl/ecpath_ctrl.sv
module ecpath_ctrl
  import ecpath_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slotValid,
  input  logic          ctlWe,
  input  logic [CW-1:0] ctlChan,
  input  chanCtl_t      ctlBits,
  output slotStrobe_t   strobe,
  output logic [CW-1:0] chan
);
  chanCtl_t   pend    [NCH];
  chanCtl_t   act     [NCH];
  chanCtl_t   pendNext[NCH];
  logic [NCH-1:0] doneFlag;
  logic       frameEnd;
  chanCtl_t   cur;

  assign frameEnd = slotValid && (chan == CW'(NCH-1));

  // Staged words with the current write folded in, so a write in the
  // last slot of a frame is not lost at the boundary copy.
  always_comb begin
    for (int i = 0; i < NCH; i++)
      pendNext[i] = (ctlWe && ctlChan == CW'(i)) ? ctlBits : pend[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chan     <= '0;
      doneFlag <= '0;
      for (int i = 0; i < NCH; i++) begin
        pend[i] <= '0;
        act[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) pend[i] <= pendNext[i];
      if (slotValid) chan <= frameEnd ? '0 : chan + 1'b1;
      if (frameEnd) begin
        for (int i = 0; i < NCH; i++) begin
          act[i]      <= pendNext[i];
          doneFlag[i] <= act[i].bypass & pendNext[i].bypass;
        end
      end
    end
  end

  assign cur = act[chan];

  always_comb begin
    strobe.muteS      = cur.muteS;
    strobe.muteR      = cur.muteR;
    strobe.bypass     = cur.bypass;
    strobe.coefClear  = cur.bypass;
    strobe.coefFreeze = !cur.bypass && cur.adaptDis;
    strobe.coefUpdate = !cur.bypass && !cur.adaptDis;
    strobe.clearDone  = doneFlag[chan];
  end
endmodule

// File: rtl/ecpath_data.sv
module ecpath_data
  import ecpath_pkg::*;
#(
  parameter int          NCH   = 32,
  parameter int          W     = 8,
  parameter logic [W-1:0] QUIET = 8'hFF,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slotValid,
  input  logic [W-1:0]  rinData,
  input  logic [W-1:0]  sinData,
  input  logic [W-1:0]  echoEst,
  input  slotStrobe_t   strobe,
  input  logic [CW-1:0] chan,
  output logic          outValid,
  output logic [W-1:0]  rOut,
  output logic [W-1:0]  sOut,
  output logic [CW-1:0] chanO,
  output logic          coefClear,
  output logic          coefFreeze,
  output logic          coefUpdate,
  output logic          clearDone
);
  localparam int SHORT = 2 * NCH;
  localparam int EXTRA = NCH;
  localparam logic signed [W:0] SMAX = (W+1)'((1 << (W-1)) - 1);
  localparam logic signed [W:0] SMIN = -SMAX - 1;

  logic [W-1:0] rxTap, txShort, txLong, txCancel;
  logic signed [W:0] diff;

  ecpath_delay #(.W(W), .DEPTH(SHORT)) uRx (
    .clk(clk), .rstN(rstN), .en(slotValid), .dIn(rinData), .dOut(rxTap));
  ecpath_delay #(.W(W), .DEPTH(SHORT)) uTxA (
    .clk(clk), .rstN(rstN), .en(slotValid), .dIn(sinData), .dOut(txShort));
  ecpath_delay #(.W(W), .DEPTH(EXTRA)) uTxB (
    .clk(clk), .rstN(rstN), .en(slotValid), .dIn(txShort), .dOut(txLong));

  assign diff = $signed({txLong[W-1], txLong}) - $signed({echoEst[W-1], echoEst});

  always_comb begin
    if (diff > SMAX)      txCancel = SMAX[W-1:0];
    else if (diff < SMIN) txCancel = SMIN[W-1:0];
    else                  txCancel = diff[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      rOut       <= '0;
      sOut       <= '0;
      chanO      <= '0;
      coefClear  <= 1'b0;
      coefFreeze <= 1'b0;
      coefUpdate <= 1'b0;
      clearDone  <= 1'b0;
    end else begin
      outValid <= slotValid;
      if (slotValid) begin
        rOut       <= strobe.muteR ? QUIET : rxTap;
        sOut       <= strobe.muteS ? QUIET : (strobe.bypass ? txShort : txCancel);
        chanO      <= chan;
        coefClear  <= strobe.coefClear;
        coefFreeze <= strobe.coefFreeze;
        coefUpdate <= strobe.coefUpdate;
        clearDone  <= strobe.clearDone;
      end
    end
  end
endmodule

// File: rtl/echo_path_ctrl.sv
module echo_path_ctrl
  import ecpath_pkg::*;
#(
  parameter int           NCH   = 32,
  parameter int           W     = 8,
  parameter logic [W-1:0] QUIET = 8'hFF,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slotValid,
  input  logic [W-1:0]  rinData,
  input  logic [W-1:0]  sinData,
  input  logic [W-1:0]  echoEst,
  input  logic          ctlWe,
  input  logic [CW-1:0] ctlChan,
  input  logic [3:0]    ctlBits,
  output logic          outValid,
  output logic [W-1:0]  rOut,
  output logic [W-1:0]  sOut,
  output logic [CW-1:0] chanO,
  output logic          coefClear,
  output logic          coefFreeze,
  output logic          coefUpdate,
  output logic          clearDone
);
  slotStrobe_t   slotStb;
  logic [CW-1:0] slotChan;

  ecpath_ctrl #(.NCH(NCH)) uCtrl (
    .clk(clk), .rstN(rstN), .slotValid(slotValid),
    .ctlWe(ctlWe), .ctlChan(ctlChan), .ctlBits(chanCtl_t'(ctlBits)),
    .strobe(slotStb), .chan(slotChan));

  ecpath_data #(.NCH(NCH), .W(W), .QUIET(QUIET)) uData (
    .clk(clk), .rstN(rstN), .slotValid(slotValid),
    .rinData(rinData), .sinData(sinData), .echoEst(echoEst),
    .strobe(slotStb), .chan(slotChan),
    .outValid(outValid), .rOut(rOut), .sOut(sOut), .chanO(chanO),
    .coefClear(coefClear), .coefFreeze(coefFreeze), .coefUpdate(coefUpdate),
    .clearDone(clearDone));
endmodule

// File: rtl/ecpath_chk.sv
module ecpath_chk
  import ecpath_pkg::*;
#(
  parameter int           W     = 8,
  parameter logic [W-1:0] QUIET = 8'hFF
) (
  input logic         clk,
  input logic         rstN,
  input logic         slotValid,
  input slotStrobe_t  slotStb,
  input logic         outValid,
  input logic [W-1:0] rOut,
  input logic [W-1:0] sOut,
  input logic         coefClear,
  input logic         coefFreeze,
  input logic         coefUpdate,
  input logic         clearDone
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> outValid);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> (!outValid && $stable(rOut) && $stable(sOut)));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones({coefClear, coefFreeze, coefUpdate}) == 1));

  a_r7_done_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && clearDone) |-> coefClear);

  a_r4_mute_rx: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotStb.muteR) |=> (rOut == QUIET));

  a_r5_mute_tx: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotStb.muteS) |=> (sOut == QUIET));
endmodule

bind echo_path_ctrl ecpath_chk #(.W(W), .QUIET(QUIET)) uChk (
  .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotStb(slotStb),
  .outValid(outValid), .rOut(rOut), .sOut(sOut),
  .coefClear(coefClear), .coefFreeze(coefFreeze), .coefUpdate(coefUpdate),
  .clearDone(clearDone));

// File: tb/tb_echo_path_ctrl.sv
`timescale 1ns/1ps
module tb_echo_path_ctrl;
  localparam int N  = 32;
  localparam int CW = $clog2(N);
  localparam logic [7:0] Q = 8'hFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotValid = 1'b0;
  logic [7:0] rinData = '0, sinData = '0, echoEst = '0;
  logic ctlWe = 1'b0;
  logic [CW-1:0] ctlChan = '0;
  logic [3:0] ctlBits = '0;
  logic outValid, coefClear, coefFreeze, coefUpdate, clearDone;
  logic [7:0] rOut, sOut;
  logic [CW-1:0] chanO;

  always #2 clk = ~clk;

  echo_path_ctrl #(.NCH(N), .W(8), .QUIET(Q)) dut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid),
    .rinData(rinData), .sinData(sinData), .echoEst(echoEst),
    .ctlWe(ctlWe), .ctlChan(ctlChan), .ctlBits(ctlBits),
    .outValid(outValid), .rOut(rOut), .sOut(sOut), .chanO(chanO),
    .coefClear(coefClear), .coefFreeze(coefFreeze), .coefUpdate(coefUpdate),
    .clearDone(clearDone));

  typedef struct {
    logic [7:0] r, s;
    logic cl, fr, up, dn;
    int ch, tagR, tagS;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int evN = 0;
  logic [7:0] rinHist [0:4095];
  logic [7:0] sinHist [0:4095];
  logic [3:0] pendM [N];
  logic [3:0] actM  [N];
  logic       doneM [N];

  task automatic chk(input bit ok, input int tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] satSub(input logic [7:0] a, input logic [7:0] b);
    int d;
    d = $signed(a) - $signed(b);
    if (d > 127) d = 127;
    if (d < -128) d = -128;
    return 8'(d);
  endfunction

  // Driver: presents one slot and pushes the predicted result.
  task automatic doSlot(input logic [7:0] r, input logic [7:0] s, input logic [7:0] e,
                        input bit we, input int wch, input logic [3:0] wb);
    exp_t x;
    int c;
    logic [3:0] a;
    logic [7:0] r2, s2, s3;
    @(negedge clk);
    slotValid = 1'b1; rinData = r; sinData = s; echoEst = e;
    ctlWe = we; ctlChan = CW'(wch); ctlBits = wb;
    c = evN % N;
    a = actM[c];
    rinHist[evN] = r; sinHist[evN] = s;
    r2 = (evN >= 2*N) ? rinHist[evN-2*N] : 8'h00;
    s2 = (evN >= 2*N) ? sinHist[evN-2*N] : 8'h00;
    s3 = (evN >= 3*N) ? sinHist[evN-3*N] : 8'h00;
    // R1 receive delay, R4 receive mute
    x.r = a[1] ? Q : r2;
    x.tagR = a[1] ? 4 : 1;
    // R5 send mute beats R3 bypass; otherwise R2 cancellation
    x.s = a[0] ? Q : (a[2] ? s2 : satSub(s3, e));
    x.tagS = a[0] ? 5 : (a[2] ? 3 : 2);
    // R8: a staged but not yet active write must not show
    if (pendM[c] != actM[c]) begin x.tagR = 8; x.tagS = 8; end
    x.cl = a[2]; x.fr = !a[2] && a[3]; x.up = !a[2] && !a[3]; // R6
    x.dn = doneM[c];                                          // R7
    x.ch = c;                                                 // R10
    q.push_back(x);
    if (we) pendM[wch] = wb;
    if (c == N-1) begin
      for (int i = 0; i < N; i++) begin
        doneM[i] = actM[i][2] & pendM[i][2];
        actM[i] = pendM[i];
      end
    end
    evN++;
  endtask

  task automatic idle();
    @(negedge clk);
    slotValid = 1'b0; ctlWe = 1'b0;
  endtask

  // Monitor: pops and compares each produced slot.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        chk(1'b0, 10, "unexpected outValid", 1, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk(rOut == x.r, x.tagR, "rOut", rOut, x.r);
        chk(sOut == x.s, x.tagS, "sOut", sOut, x.s);
        chk({coefClear, coefFreeze, coefUpdate} == {x.cl, x.fr, x.up}, 6, "strobes",
            {coefClear, coefFreeze, coefUpdate}, {x.cl, x.fr, x.up});
        chk(clearDone == x.dn, 7, "clearDone", clearDone, x.dn);
        chk(int'(chanO) == x.ch, 10, "chanO", chanO, x.ch);
      end
    end
  end

  initial begin : watchdog
    #(4 * 150000);
    chk(1'b0, 0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] r, s, e;
    bit we;
    int wch;
    logic [3:0] wb;
    for (int i = 0; i < N; i++) begin pendM[i] = '0; actM[i] = '0; doneM[i] = 1'b0; end
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(outValid == 1'b0, 9, "outValid in reset", outValid, 0);
    chk(rOut == 8'h00 && sOut == 8'h00, 9, "data in reset", {rOut, sOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, 9, "outValid after reset", outValid, 0);
    chk(rOut == 8'h00 && sOut == 8'h00, 9, "data after reset", {rOut, sOut}, 0);

    for (int n = 0; n < 12*N; n++) begin
      int f, sl;
      f = n / N; sl = n % N;
      r = 8'($urandom); s = 8'($urandom); e = 8'($urandom);
      if (n % 11 == 0) s = 8'h7F;
      if (n % 19 == 0) s = 8'h80;
      if (n % 13 == 0) e = 8'h80;
      if (n % 17 == 0) e = 8'h7F;
      we = 1'b0; wch = 0; wb = '0;
      if (f == 4) begin
        case (sl)
          10: begin we = 1; wch = 3;  wb = 4'b0010; end // R4
          11: begin we = 1; wch = 5;  wb = 4'b0001; end // R5
          12: begin we = 1; wch = 7;  wb = 4'b0100; end // R3
          13: begin we = 1; wch = 9;  wb = 4'b1000; end // R6 freeze
          14: begin we = 1; wch = 11; wb = 4'b0101; end // R5 over R3
          15: begin we = 1; wch = 13; wb = 4'b1100; end // R6 clear wins
          31: begin we = 1; wch = 0;  wb = 4'b0110; end // R8 boundary write
          default: ;
        endcase
      end
      if (f == 9) begin
        case (sl)
          2:  begin we = 1; wch = 3;  wb = 4'b0000; end // R8 mid-frame
          20: begin we = 1; wch = 7;  wb = 4'b0000; end // R7 release
          21: begin we = 1; wch = 13; wb = 4'b1000; end
          default: ;
        endcase
      end
      doSlot(r, s, e, we, wch, wb);
      if (n % 7 == 6) begin
        idle(); // R10 hold across gaps
      end
    end
    idle();
    idle();
    idle();
    chk(q.size() == 0, 10, "pending results", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule